// File: doc/BRIEF.md
# Parallel-Port Wake-Up Sequence Detector

This block sits on the adapter side of a host parallel port. It watches the eight data lines and the four control lines. It arms only after the host writes a fixed seven-byte unlock pattern, one byte at a time. The pattern bytes are FE, AA, 55, 00, FF, 87 and 78, in that order. The byte that follows the pattern is the command byte.

The command is taken when the host pulses the control lines from 4 to 5 and back to 4 while the command byte is still on the data lines. Command 0x20 raises the link flag and command 0x30 drops it. Any other command is latched but does not change the link flag. Writing a new byte after the pulse, by convention FF, ends the sequence.

The host can also probe for the adapter. While the sequence is in progress, the block places an identification code, one nibble at a time, on the upper status lines, so the host reads 0xB5F. A byte is counted only when the value on the data lines changes. All inputs are assumed to be synchronous to `clk`.

Top module: `pp_unlock_detector`

## Requirements
- R1: After reset, `link_up` is 0, `cmd_last` is 0x00 and `id_nibble` is 0x0.
- R2: A command is accepted only after the full pattern FE, AA, 55, 00, FF, 87, 78 and one further byte. The control lines must then go 4, 5, 4 while that byte stays on the data lines. On acceptance, `cmd_last` takes the command byte in the cycle after the control lines return to 4.
- R3: Accepting command 0x20 sets `link_up` to 1.
- R4: Accepting command 0x30 clears `link_up` to 0.
- R5: `id_nibble` is 0xB while FF is the last matched pattern byte. It is 0x5 while 87 is the last matched pattern byte. Each nibble appears one cycle after its byte is driven.
- R6: `id_nibble` is 0xF while the control lines are at 5 during the pulse for command byte 0x20, and 0x0 at all other times outside the R5 windows. This includes the pulse for any other command.
- R7: A new byte that does not match the next expected pattern byte returns the matcher to idle, so a later pulse has no effect. If that byte is FE, matching restarts from the second pattern position.
- R8: Holding a byte on the data lines for several cycles counts as one byte, so a slowly written pattern is still recognised.
- R9: An accepted command other than 0x20 or 0x30 updates `cmd_last` and leaves `link_up` unchanged.
- R10: A control pulse 4, 5, 4 without a preceding complete pattern and command byte changes neither `link_up` nor `cmd_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pp_data | input | 8 | Host data lines |
| pp_ctrl | input | 4 | Host control lines |
| link_up | output | 1 | Adapter connected flag |
| cmd_last | output | 8 | Last accepted command byte |
| id_nibble | output | 4 | Upper status nibble returned to the host |

## Verification
Some properties are checked by assertions on every cycle:
- the link flag moves only in the cycle after an acceptance, and only for the matching command;
- `cmd_last` is stable except after an acceptance;
- the status nibble keeps to its four legal codes;
- 0xF is shown only while the control lines were at 5;
- an acceptance happens only on a return from 5 to 4 with no data change.

Other behaviours can only be shown by the bench scenarios:
- the exact order of the pattern and the return to idle when it breaks;
- the restart on FE;
- the filtering of repeated bytes;
- the ignoring of unknown commands and of stray pulses.

// File: rtl/pp_unlock_pkg.sv
package pp_unlock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MATCH,
    ST_ARMED,
    ST_CMD,
    ST_STROBE,
    ST_CLOSE
  } unl_state_e;

  // number of bytes in the unlock pattern (command byte excluded)
  localparam int SEQ_LEN  = 7;
  localparam int IDX_W    = $clog2(SEQ_LEN + 1);
  // pattern positions whose match selects an identification nibble
  localparam int POS_FF   = 4;
  localparam int POS_87   = 5;

  function automatic logic [7:0] seq_byte(input int i);
    case (i)
      0:       return 8'hFE;
      1:       return 8'hAA;
      2:       return 8'h55;
      3:       return 8'h00;
      4:       return 8'hFF;
      5:       return 8'h87;
      6:       return 8'h78;
      default: return 8'hFE;
    endcase
  endfunction

  // nibble number n (0 = most significant) of a 12-bit code
  function automatic logic [3:0] code_nibble(input logic [11:0] code, input int n);
    return code[11 - 4*n -: 4];
  endfunction

endpackage

// File: rtl/pp_change_detect.sv
module pp_change_detect #(
  parameter int          W         = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RESET_VAL;
    else     prev_q <= cur;
  end

  assign changed = (cur != prev_q);
endmodule

// File: rtl/pp_strobe_detect.sv
module pp_strobe_detect #(
  parameter int           CW        = 4,
  parameter logic [CW-1:0] REST_VAL = 4'h4,
  parameter logic [CW-1:0] HIGH_VAL = 4'h5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ctrl,
  output logic          rise_evt,
  output logic          fall_evt,
  output logic          other_evt
);
  logic [CW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= REST_VAL;
    else     ctrl_q <= ctrl;
  end

  assign rise_evt  = (ctrl_q == REST_VAL) && (ctrl == HIGH_VAL);
  assign fall_evt  = (ctrl_q == HIGH_VAL) && (ctrl == REST_VAL);
  assign other_evt = (ctrl != ctrl_q) && !rise_evt && !fall_evt;
endmodule

// File: rtl/pp_unlock_fsm.sv
module pp_unlock_fsm
  import pp_unlock_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_evt,
  input  logic [DW-1:0]    byte_val,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             other_evt,
  output unl_state_e       state,
  output logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    cmd_byte,
  output logic             accept_evt
);
  unl_state_e       st_n;
  logic [IDX_W-1:0] idx_n;
  logic [DW-1:0]    cmd_n;
  logic             is_start;
  logic             is_expected;

  assign is_start    = (byte_val == DW'(seq_byte(0)));
  assign is_expected = (byte_val == DW'(seq_byte(int'(idx))));

  always_comb begin
    st_n       = state;
    idx_n      = idx;
    cmd_n      = cmd_byte;
    accept_evt = 1'b0;
    if (byte_evt) begin
      case (state)
        ST_MATCH: begin
          if (is_expected) begin
            idx_n = idx + 1'b1;
            if (idx == IDX_W'(SEQ_LEN - 1)) st_n = ST_ARMED;
          end else begin
            st_n  = is_start ? ST_MATCH : ST_IDLE;
            idx_n = is_start ? IDX_W'(1) : '0;
          end
        end
        ST_ARMED: begin
          st_n  = ST_CMD;
          cmd_n = byte_val;
        end
        default: begin
          st_n  = is_start ? ST_MATCH : ST_IDLE;
          idx_n = is_start ? IDX_W'(1) : '0;
        end
      endcase
    end else begin
      case (state)
        ST_CMD:
          if (rise_evt) st_n = ST_STROBE;
        ST_STROBE: begin
          if (fall_evt) begin
            st_n       = ST_CLOSE;
            accept_evt = 1'b1;
          end else if (other_evt) begin
            st_n  = ST_IDLE;
            idx_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      cmd_byte <= '0;
    end else begin
      state    <= st_n;
      idx      <= idx_n;
      cmd_byte <= cmd_n;
    end
  end
endmodule

// File: rtl/pp_link_ctrl.sv
module pp_link_ctrl #(
  parameter int           DW       = 8,
  parameter logic [DW-1:0] CMD_UP   = 8'h20,
  parameter logic [DW-1:0] CMD_DOWN = 8'h30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_evt,
  input  logic [DW-1:0] cmd_byte,
  output logic          link_up,
  output logic [DW-1:0] cmd_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_up  <= 1'b0;
      cmd_last <= '0;
    end else if (accept_evt) begin
      cmd_last <= cmd_byte;
      if (cmd_byte == CMD_UP)        link_up <= 1'b1;
      else if (cmd_byte == CMD_DOWN) link_up <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_id_nibble.sv
module pp_id_nibble
  import pp_unlock_pkg::*;
#(
  parameter int           DW      = 8,
  parameter logic [11:0]  ID_CODE = 12'hB5F,
  parameter logic [3:0]   QUIET   = 4'h0,
  parameter logic [DW-1:0] CMD_UP = 8'h20
) (
  input  unl_state_e       state,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    cmd_byte,
  output logic [3:0]       nibble
);
  always_comb begin
    nibble = QUIET;
    if (state == ST_MATCH && idx == IDX_W'(POS_FF + 1))
      nibble = code_nibble(ID_CODE, 0);
    else if (state == ST_MATCH && idx == IDX_W'(POS_87 + 1))
      nibble = code_nibble(ID_CODE, 1);
    else if (state == ST_STROBE && cmd_byte == CMD_UP)
      nibble = code_nibble(ID_CODE, 2);
  end
endmodule

// File: rtl/pp_unlock_detector.sv
module pp_unlock_detector
  import pp_unlock_pkg::*;
#(
  parameter int           DW        = 8,
  parameter int           CW        = 4,
  parameter logic [CW-1:0] CTRL_REST = 4'h4,
  parameter logic [CW-1:0] CTRL_HIGH = 4'h5,
  parameter logic [DW-1:0] CMD_UP    = 8'h20,
  parameter logic [DW-1:0] CMD_DOWN  = 8'h30,
  parameter logic [11:0]   ID_CODE   = 12'hB5F,
  parameter logic [3:0]    QUIET     = 4'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pp_data,
  input  logic [CW-1:0] pp_ctrl,
  output logic          link_up,
  output logic [DW-1:0] cmd_last,
  output logic [3:0]    id_nibble
);
  // named internal events, also observed by the bound checker
  logic             byte_evt;
  logic             rise_evt;
  logic             fall_evt;
  logic             other_evt;
  logic             accept_evt;
  unl_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    cmd_byte;

  pp_change_detect #(.W(DW), .RESET_VAL('0)) u_data_chg (
    .clk(clk), .rst(rst), .cur(pp_data), .changed(byte_evt)
  );

  pp_strobe_detect #(.CW(CW), .REST_VAL(CTRL_REST), .HIGH_VAL(CTRL_HIGH)) u_strobe (
    .clk(clk), .rst(rst), .ctrl(pp_ctrl),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .other_evt(other_evt)
  );

  pp_unlock_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .byte_evt(byte_evt), .byte_val(pp_data),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .other_evt(other_evt),
    .state(state), .idx(idx), .cmd_byte(cmd_byte), .accept_evt(accept_evt)
  );

  pp_link_ctrl #(.DW(DW), .CMD_UP(CMD_UP), .CMD_DOWN(CMD_DOWN)) u_link (
    .clk(clk), .rst(rst), .accept_evt(accept_evt), .cmd_byte(cmd_byte),
    .link_up(link_up), .cmd_last(cmd_last)
  );

  pp_id_nibble #(.DW(DW), .ID_CODE(ID_CODE), .QUIET(QUIET), .CMD_UP(CMD_UP)) u_id (
    .state(state), .idx(idx), .cmd_byte(cmd_byte), .nibble(id_nibble)
  );
endmodule

// File: rtl/pp_unlock_detector_chk.sv
module pp_unlock_detector_chk #(
  parameter int           DW        = 8,
  parameter int           CW        = 4,
  parameter logic [CW-1:0] CTRL_REST = 4'h4,
  parameter logic [CW-1:0] CTRL_HIGH = 4'h5,
  parameter logic [DW-1:0] CMD_UP    = 8'h20,
  parameter logic [DW-1:0] CMD_DOWN  = 8'h30,
  parameter logic [11:0]   ID_CODE   = 12'hB5F,
  parameter logic [3:0]    QUIET     = 4'h0
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] pp_ctrl,
  input logic          link_up,
  input logic [DW-1:0] cmd_last,
  input logic [3:0]    id_nibble,
  input logic          byte_evt,
  input logic          accept_evt
);
  p_link_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(accept_evt) && cmd_last == CMD_UP);

  p_link_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(link_up) |-> $past(accept_evt) && cmd_last == CMD_DOWN);

  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(accept_evt) |-> $stable(cmd_last));

  p_unknown_keeps_link_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(accept_evt) && cmd_last != CMD_UP && cmd_last != CMD_DOWN) |-> $stable(link_up));

  p_nibble_legal_r5: assert property (@(posedge clk) disable iff (rst)
    id_nibble == QUIET || id_nibble == ID_CODE[11:8] ||
    id_nibble == ID_CODE[7:4] || id_nibble == ID_CODE[3:0]);

  p_tail_nibble_r6: assert property (@(posedge clk) disable iff (rst)
    (id_nibble == ID_CODE[3:0] && ID_CODE[3:0] != ID_CODE[11:8] &&
     ID_CODE[3:0] != ID_CODE[7:4] && ID_CODE[3:0] != QUIET) |-> $past(pp_ctrl) == CTRL_HIGH);

  p_accept_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    accept_evt |-> pp_ctrl == CTRL_REST && !byte_evt && $past(pp_ctrl) == CTRL_HIGH);
endmodule

bind pp_unlock_detector pp_unlock_detector_chk #(
  .DW(DW), .CW(CW), .CTRL_REST(CTRL_REST), .CTRL_HIGH(CTRL_HIGH),
  .CMD_UP(CMD_UP), .CMD_DOWN(CMD_DOWN), .ID_CODE(ID_CODE), .QUIET(QUIET)
) u_chk (
  .clk(clk), .rst(rst), .pp_ctrl(pp_ctrl), .link_up(link_up),
  .cmd_last(cmd_last), .id_nibble(id_nibble), .byte_evt(byte_evt),
  .accept_evt(accept_evt)
);

// File: tb/pp_unlock_detector_test.sv
`timescale 1ns/1ps
module pp_unlock_detector_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pp_data = 8'h00;
  logic [3:0] pp_ctrl = 4'h4;
  logic       link_up;
  logic [7:0] cmd_last;
  logic [3:0] id_nibble;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pp_unlock_detector uut (
    .clk(clk), .rst(rst), .pp_data(pp_data), .pp_ctrl(pp_ctrl),
    .link_up(link_up), .cmd_last(cmd_last), .id_nibble(id_nibble)
  );

  // vector: {data, ctrl, expected link, expected cmd, expected nibble}
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {8'hFE, 4'h4, 1'b0, 8'h00, 4'h0},
    {8'hAA, 4'h4, 1'b0, 8'h00, 4'h0},
    {8'h55, 4'h4, 1'b0, 8'h00, 4'h0},
    {8'h00, 4'h4, 1'b0, 8'h00, 4'h0},
    {8'hFF, 4'h4, 1'b0, 8'h00, 4'hB},
    {8'h87, 4'h4, 1'b0, 8'h00, 4'h5},
    {8'h78, 4'h4, 1'b0, 8'h00, 4'h0},
    {8'h20, 4'h4, 1'b0, 8'h00, 4'h0},
    {8'h20, 4'h5, 1'b0, 8'h00, 4'hF},
    {8'h20, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'hFF, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'hFE, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'hAA, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'h55, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'h00, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'hFF, 4'h4, 1'b1, 8'h20, 4'hB},
    {8'h87, 4'h4, 1'b1, 8'h20, 4'h5},
    {8'h78, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'h30, 4'h4, 1'b1, 8'h20, 4'h0},
    {8'h30, 4'h5, 1'b1, 8'h20, 4'h0},
    {8'h30, 4'h4, 1'b0, 8'h30, 4'h0},
    {8'hFF, 4'h4, 1'b0, 8'h30, 4'h0}
  };

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive a byte and hold it for 'hold' cycles; sample at the last negedge
  task automatic put(input logic [7:0] b, input int hold);
    @(negedge clk);
    pp_data = b;
    repeat (hold) @(negedge clk);
  endtask

  task automatic pattern(input int hold);
    put(8'hFE, hold); put(8'hAA, hold); put(8'h55, hold); put(8'h00, hold);
    put(8'hFF, hold); put(8'h87, hold); put(8'h78, hold);
  endtask

  // control pulse 4 -> 5 -> 4; returns the nibble seen while at 5
  task automatic pulse(input int hold, output logic [3:0] hi_nib);
    @(negedge clk);
    pp_ctrl = 4'h5;
    repeat (hold) @(negedge clk);
    hi_nib = id_nibble;
    pp_ctrl = 4'h4;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] hn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 link", 12'(link_up), 12'h0);
    chk("R1 cmd", 12'(cmd_last), 12'h00);
    chk("R1 nibble", 12'(id_nibble), 12'h0);

    // table: connect (R2 R3 R5 R6) then disconnect (R4)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pp_data = VEC[i][24:17];
      pp_ctrl = VEC[i][16:13];
      @(negedge clk);
      chk($sformatf("R2/R3/R4 link step %0d", i), 12'(link_up), 12'(VEC[i][12]));
      chk($sformatf("R2 cmd step %0d", i), 12'(cmd_last), 12'(VEC[i][11:4]));
      chk($sformatf("R5/R6 nibble step %0d", i), 12'(id_nibble), 12'(VEC[i][3:0]));
    end

    // R7: broken pattern has no effect
    put(8'hFE, 1); put(8'hAA, 1); put(8'h12, 1); put(8'h55, 1); put(8'h00, 1);
    put(8'hFF, 1);
    chk("R7 no id after break", 12'(id_nibble), 12'h0);
    put(8'h87, 1); put(8'h78, 1); put(8'h20, 1);
    pulse(1, hn);
    chk("R7 link after break", 12'(link_up), 12'h0);
    chk("R7 cmd after break", 12'(cmd_last), 12'h30);
    // R7: FE mid-pattern restarts
    put(8'hFE, 1); put(8'hAA, 1);
    pattern(1);
    put(8'h20, 1);
    pulse(1, hn);
    chk("R7 restart link", 12'(link_up), 12'h1);
    chk("R7 restart cmd", 12'(cmd_last), 12'h20);
    put(8'hFF, 1);

    // R9: unknown command
    pattern(1);
    put(8'h44, 1);
    pulse(1, hn);
    chk("R6 no F for other cmd", 12'(hn), 12'h0);
    chk("R9 cmd latched", 12'(cmd_last), 12'h44);
    chk("R9 link unchanged", 12'(link_up), 12'h1);
    put(8'hFF, 1);

    // R10: stray pulse
    put(8'h30, 1);
    pulse(1, hn);
    chk("R10 link", 12'(link_up), 12'h1);
    chk("R10 cmd", 12'(cmd_last), 12'h44);

    // R8: slow writes with held bytes
    put(8'hFE, 3); put(8'hAA, 3); put(8'h55, 3); put(8'h00, 3);
    put(8'hFF, 3);
    chk("R8 held FF nibble", 12'(id_nibble), 12'hB);
    put(8'h87, 3);
    chk("R8 held 87 nibble", 12'(id_nibble), 12'h5);
    put(8'h78, 3); put(8'h30, 3);
    pulse(3, hn);
    chk("R8 slow disconnect link", 12'(link_up), 12'h0);
    chk("R8 slow cmd", 12'(cmd_last), 12'h30);
    chk("R6 quiet after pulse", 12'(id_nibble), 12'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule